// File: doc/BRIEF.md
# Parallel-Enable Byte-Sliced Incrementer/Decrementer

This block adds or subtracts one from an N-bit word, where N is a multiple of eight. The word is cut into byte slices. A mode input selects the operation. When it is 1 the block works on the complemented word, so the same find-the-lowest-one logic gives an increment. When it is 0 it works on the word as given, which gives a decrement. The result and a wrap flag are registered on the rising clock edge, so a new word can be applied every cycle.

Each slice reads its selected byte and finds the lowest set bit. It then flips that bit and every bit below it. The slice at bits 7..0 is always enabled. Every slice above it is enabled only when all the selected bytes below it are zero. That enable is a single AND of per-byte zero tests, and all of them are computed from the data at the same time. No enable passes from one slice to the next.

Only one slice can contain the lowest active bit. That slice modifies its byte. The zero-valued slices under it invert their whole byte to finish the carry or the borrow. Every slice above it passes its byte through. When the whole selected word is zero there is nothing to add to or take from. In that case the output equals the input and the wrap flag is set.

Top module: `byte_step_incdec`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the result is cleared to zero and the wrap flag is cleared after that edge.
- R2: With the mode input at 1, the result one edge after the word is sampled equals the word plus one, modulo 2^N. This holds unless the word is all ones.
- R3: With the mode input at 0, the result one edge after the word is sampled equals the word minus one, modulo 2^N. This holds unless the word is zero.
- R4: Incrementing an all-ones word, or decrementing a zero word, gives a result equal to the input word, and the wrap flag is 1 for that result. For every other word the flag is 0.
- R5: Bytes above the lowest byte whose selected value is nonzero reach the result unchanged. At most one slice applies a partial flip in any cycle.
- R6: Whole bytes whose selected value is zero, and which lie below the active byte, are inverted in full. For example, 0x0100 minus one gives 0x00FF, and 0x0000FFFF plus one gives 0x00010000.
- R7: The width N is a parameter that must be a multiple of eight and at least 16. The defaults use N = 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inc | input | 1 | 1 = add one, 0 = subtract one |
| din | input | N | Operand word |
| q | output | N | Registered result |
| wrap | output | 1 | Registered flag: the operand had no successor or predecessor within N bits |

## Verification
The bench targets carries and borrows that cross byte boundaries. These include 0x000000FF and 0x0000FFFF incremented, and 0x00000100 and 0x00010000 decremented. A design that built its enables from the raw input instead of the selected word would leave the upper byte unchanged on these, or would skip the inversion of the lower bytes. The bench also drives the two wrap words, all ones in increment mode and zero in decrement mode. A design that got these wrong would return zero or all ones, or would leave the flag low. It also drives the sign-boundary words 0x7FFFFFFF and 0x80000000, and random words in both modes. A slice whose enable was wired wrongly would change bytes above the active one, and the bench would see that as a value mismatch.

// File: rtl/byte_step_incdec.sv
module byte_step_incdec #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic         wrap
);
  localparam int S = N / 8;

  logic [N-1:0] d;
  logic [N-1:0] flip;
  logic [S-1:0] nz;
  logic [S-1:0] en;
  logic [S-1:0] hi;
  logic [S-1:0] act;

  assign d = inc ? ~din : din;

  genvar k, j;
  generate
    for (k = 0; k < S; k++) begin : g_slice
      logic [7:0] db;
      logic [7:0] therm;
      assign db    = d[8*k +: 8];
      assign nz[k] = |db;

      if (k == 0) begin : g_first
        assign en[k] = 1'b1;
      end else begin : g_rest
        assign en[k] = ~|nz[k-1:0];
      end

      if (k == S-1) begin : g_top
        assign hi[k] = 1'b0;
      end else begin : g_mid
        assign hi[k] = |nz[S-1:k+1];
      end

      for (j = 0; j < 8; j++) begin : g_bit
        if (j == 0) begin : g_b0
          assign therm[j] = nz[k];
        end else begin : g_bn
          assign therm[j] = nz[k] & ~|db[j-1:0];
        end
      end

      assign act[k] = en[k] & nz[k];
      assign flip[8*k +: 8] = !en[k] ? 8'h00 : (nz[k] ? therm : {8{hi[k]}});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      wrap <= 1'b0;
    end else begin
      q    <= din ^ flip;
      wrap <= ~|d;
    end
  end

  // R4
  wrap_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && wrap) |-> (q == $past(din)));

  // R2
  inc_value_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(inc) && !wrap) |-> (q == $past(din) + 1'b1));

  // R3
  dec_value_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(inc) && !wrap) |-> (q == $past(din) - 1'b1));

  // R5
  one_slice_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act));

  // R4
  wrap_no_slice_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && wrap) |-> ($past(act) == '0));
endmodule

// File: tb/sim_byte_step_incdec.sv
module sim_byte_step_incdec;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inc = 1'b0;
  logic [N-1:0] din = '0;
  logic [N-1:0] q;
  logic         wrap;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_step_incdec #(.N(N)) u0 (
    .clk(clk), .rst(rst), .inc(inc), .din(din), .q(q), .wrap(wrap)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [N-1:0] exp_q, logic exp_w);
    compared++;
    if (q !== exp_q || wrap !== exp_w) begin
      mismatched++;
      $display("FAIL %s: q=%h wrap=%b expected q=%h wrap=%b", tag, q, wrap, exp_q, exp_w);
    end
  endtask

  task automatic apply(string tag, logic [N-1:0] v, logic mode);
    logic [N-1:0] e;
    logic w;
    @(negedge clk);
    din = v;
    inc = mode;
    w = mode ? (v == '1) : (v == '0);
    if (w) e = v;
    else if (mode) e = v + 1'b1;
    else e = v - 1'b1;
    @(posedge clk);
    #2;
    check(tag, e, w);
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: q=%h wrap=%b expected completion", q, wrap);
    finish_run();
  end

  initial begin
    din = 32'hDEAD_BEEF;
    inc = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    apply("R2 plain inc", 32'h0000_0010, 1'b1);
    apply("R3 plain dec", 32'h0000_0010, 1'b0);
    apply("R6 inc 0x00FF", 32'h0000_00FF, 1'b1);
    apply("R6 dec 0x0100", 32'h0000_0100, 1'b0);
    apply("R6 inc 0xFFFF", 32'h0000_FFFF, 1'b1);
    apply("R6 dec 0x10000", 32'h0001_0000, 1'b0);
    apply("R6 inc 0xFFFFFF", 32'h00FF_FFFF, 1'b1);
    apply("R6 dec 0x1000000", 32'h0100_0000, 1'b0);
    apply("R4 inc all ones", 32'hFFFF_FFFF, 1'b1);
    apply("R4 dec zero", 32'h0000_0000, 1'b0);
    apply("R3 dec all ones", 32'hFFFF_FFFF, 1'b0);
    apply("R2 inc zero", 32'h0000_0000, 1'b1);
    apply("R2 inc sign edge", 32'h7FFF_FFFF, 1'b1);
    apply("R3 dec sign edge", 32'h8000_0000, 1'b0);
    apply("R5 upper pass inc", 32'hA5C3_00FE, 1'b1);
    apply("R5 upper pass dec", 32'h5A3C_8000, 1'b0);
    apply("R7 top byte borrow", 32'h8000_0000, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] v;
      v = N'($urandom);
      if (i % 4 == 1) v[15:0] = 16'h0000;
      if (i % 4 == 2) v[15:0] = 16'hFFFF;
      apply((i % 2 == 0) ? "R2 random inc" : "R3 random dec", v, (i % 2 == 0));
    end

    @(negedge clk);
    rst = 1'b1;
    din = 32'h1234_5678;
    @(posedge clk);
    #2;
    check("R1 mid-run reset", '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    apply("R2 after reset", 32'h1234_5678, 1'b1);

    finish_run();
  end
endmodule